// File: doc/BRIEF.md
# Privileged Control Register File

This block keeps the four control registers of a processor core and serves them through a single request port. Each request carries a register index, a write enable and write data. One clock later the block answers with read data and a fault flag. Every request is checked against the core's privilege flag. Software that is not privileged cannot observe or change any control register.

Index 0 is a read-only identity word. The block builds it from a CPU number and a core number, which arrive on static inputs. Index 1 holds the exception vector table base and index 2 holds the page table base. Both accept any 32-bit value. Index 3 is a small behaviour-flag word with per-bit write masking:

- bit 0 enables paging;
- bit 1 reports emulation;
- bit 2 reports JIT;
- bit 3 enables verbose debugging.

A hardware build reports emulation as zero, which also leaves the JIT bit at zero. The registered paging-enable bit is driven on its own output so that the translation logic can use it directly.

Top module: `ctrl_reg_file`

## Requirements
- R1: A synchronous active-high reset clears the address registers and the flag word to zero, drives `pte_en_o` low, and drives `rsp_fault_o` and `rsp_rdata_o` to zero.
- R2: A request with `priv_i` low faults. `rsp_fault_o` is high for exactly the next cycle, `rsp_rdata_o` is zero and no register changes. This holds whatever the index or write enable.
- R3: A request whose index is above 3 faults in the next cycle with zero read data and changes no register, even when privileged.
- R4: A privileged read of index 0 returns the CPU number in bits 31:16 and the core number in bits 15:0, without a fault.
- R5: A privileged write to index 0 is ignored without a fault. The identity word still follows the static inputs afterwards.
- R6: A privileged write to index 1 stores all 32 bits unchanged, with no alignment check, and a later read returns them.
- R7: A privileged write to index 2 stores all 32 bits unchanged, with no alignment check, and a later read returns them.
- R8: In index 3, only bit 0 (paging enable) and bit 3 (verbose debug) are writable. Bit 1 (emulated) and bit 2 (JIT) always read zero, and bits 31:4 read zero and ignore writes.
- R9: `pte_en_o` equals the stored bit 0 of index 3 and changes in the cycle after the write that sets or clears it.
- R10: Responses come one cycle after the request. A cycle without a request, and a granted write, both give zero read data and no fault. Back-to-back requests are each answered in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Current privileged-mode flag of the core |
| cpu_num_i | input | 16 | Static CPU number for the identity word |
| core_num_i | input | 16 | Static core number for the identity word |
| req_valid_i | input | 1 | Request strobe, one per access |
| req_idx_i | input | IDX_W (3) | Control register index |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, one cycle after the request |
| rsp_fault_o | output | 1 | Fault pulse, one cycle after a refused request |
| pte_en_o | output | 1 | Registered paging-enable bit |

## Verification
The assertions check on every cycle the relations that hold from one request to its response:

- refused requests fault with zero data and leave paging enable untouched;
- out-of-range indices fault;
- identity reads carry the CPU and core fields;
- writes to index 0 never fault;
- idle cycles stay quiet;
- flag-word reads never show the read-only or unused bits;
- paging enable follows the written bit 0.

Only the bench scenarios can show that a stored address survives and reads back intact, and that a refused write leaves the stored values as they were. Those checks need a full write-then-read history that the bench's reference model tracks, and a one-cycle property cannot express them.

// File: rtl/cr_pkg.sv
package cr_pkg;

    localparam int CR_W   = 32;
    localparam int HALF_W = CR_W / 2;

    typedef enum logic [1:0] {
        CR_IDENT = 2'd0,
        CR_EVT   = 2'd1,
        CR_PGT   = 2'd2,
        CR_FLAGS = 2'd3
    } cr_sel_e;

    // Bit positions inside the behaviour-flag word
    localparam int FLG_PTE = 0;
    localparam int FLG_EMU = 1;
    localparam int FLG_JIT = 2;
    localparam int FLG_DBG = 3;

    localparam logic [CR_W-1:0] FLG_WR_MASK =
        (CR_W'(1) << FLG_PTE) | (CR_W'(1) << FLG_DBG);

    typedef struct packed {
        logic    grant;
        logic    fault;
        logic    wr;
        logic    rd;
        cr_sel_e sel;
    } cr_decision_t;

    typedef struct packed {
        logic [CR_W-1:0] rdata;
        logic            fault;
    } cr_resp_t;

    function automatic logic [CR_W-1:0] make_ident(
        input logic [HALF_W-1:0] cpu,
        input logic [HALF_W-1:0] core
    );
        return {cpu, core};
    endfunction

    // Masked update: writable bits take new data, the rest stay zero
    function automatic logic [CR_W-1:0] flag_update(input logic [CR_W-1:0] wdata);
        return wdata & FLG_WR_MASK;
    endfunction

endpackage

// File: rtl/cr_access_check.sv
module cr_access_check
    import cr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NUM_CR = 4
) (
    input  logic             valid,
    input  logic             priv,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    output cr_decision_t     dec
);
    localparam int SEL_W = $clog2(NUM_CR);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CR - 1);

    logic in_range;

    always_comb begin
        in_range  = (idx <= LAST_IDX);
        dec.grant = valid && priv && in_range;
        dec.fault = valid && !dec.grant;
        dec.wr    = dec.grant && we;
        dec.rd    = dec.grant && !we;
        dec.sel   = cr_sel_e'(idx[SEL_W-1:0]);
    end

endmodule

// File: rtl/cr_addr_bank.sv
module cr_addr_bank
    import cr_pkg::*;
#(
    parameter int NUM_ADDR = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_ADDR-1:0]            wr_en,
    input  logic [CR_W-1:0]                wdata,
    output logic [NUM_ADDR-1:0][CR_W-1:0]  q
);
    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (wr_en[i]) begin
                q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/cr_flag_reg.sv
module cr_flag_reg
    import cr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [CR_W-1:0] wdata,
    output logic [CR_W-1:0] flags,
    output logic            pte_en
);
    logic [CR_W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= flag_update(wdata);
        end
    end

    // Emulated and JIT bits are hard zero in a hardware build
    assign flags  = flags_q & FLG_WR_MASK;
    assign pte_en = flags_q[FLG_PTE];

endmodule

// File: rtl/ctrl_reg_file.sv
module ctrl_reg_file
    import cr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NUM_CR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_i,
    input  logic [HALF_W-1:0] cpu_num_i,
    input  logic [HALF_W-1:0] core_num_i,
    input  logic              req_valid_i,
    input  logic [IDX_W-1:0]  req_idx_i,
    input  logic              req_we_i,
    input  logic [CR_W-1:0]   req_wdata_i,
    output logic [CR_W-1:0]   rsp_rdata_o,
    output logic              rsp_fault_o,
    output logic              pte_en_o
);
    localparam int NUM_ADDR = NUM_CR - 2;

    cr_decision_t                  dec;
    logic [NUM_ADDR-1:0]           addr_we;
    logic [NUM_ADDR-1:0][CR_W-1:0] addr_q;
    logic [CR_W-1:0]               flags;
    logic [CR_W-1:0]               rd_mux;
    cr_resp_t                      resp_d, resp_q;

    cr_access_check #(.IDX_W(IDX_W), .NUM_CR(NUM_CR)) u_check (
        .valid (req_valid_i),
        .priv  (priv_i),
        .we    (req_we_i),
        .idx   (req_idx_i),
        .dec   (dec)
    );

    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_addr_we
        assign addr_we[i] = dec.wr && (dec.sel == cr_sel_e'(2'(i + 1)));
    end

    cr_addr_bank #(.NUM_ADDR(NUM_ADDR)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (addr_we),
        .wdata (req_wdata_i),
        .q     (addr_q)
    );

    cr_flag_reg u_flags (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (dec.wr && (dec.sel == CR_FLAGS)),
        .wdata  (req_wdata_i),
        .flags  (flags),
        .pte_en (pte_en_o)
    );

    always_comb begin
        unique case (dec.sel)
            CR_IDENT: rd_mux = make_ident(cpu_num_i, core_num_i);
            CR_EVT:   rd_mux = addr_q[0];
            CR_PGT:   rd_mux = addr_q[1];
            default:  rd_mux = flags;
        endcase
        resp_d.rdata = dec.rd ? rd_mux : '0;
        resp_d.fault = dec.fault;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_rdata_o = resp_q.rdata;
    assign rsp_fault_o = resp_q.fault;

endmodule

// File: rtl/cr_checker.sv
module cr_checker
    import cr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int NUM_CR = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              priv_i,
    input logic [HALF_W-1:0] cpu_num_i,
    input logic [HALF_W-1:0] core_num_i,
    input logic              req_valid_i,
    input logic [IDX_W-1:0]  req_idx_i,
    input logic              req_we_i,
    input logic [CR_W-1:0]   req_wdata_i,
    input logic [CR_W-1:0]   rsp_rdata_o,
    input logic              rsp_fault_o,
    input logic              pte_en_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CR - 1);

    logic priv_ok;
    assign priv_ok = req_valid_i && priv_i && (req_idx_i <= LAST);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!pte_en_o && !rsp_fault_o && rsp_rdata_o == '0)); // R1

    AST_UNPRIV_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !priv_i) |=> (rsp_fault_o && rsp_rdata_o == '0)); // R2

    AST_UNPRIV_KEEP_PTE: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !priv_i) |=> $stable(pte_en_o)); // R2

    AST_BAD_IDX_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_idx_i > LAST) |=> (rsp_fault_o && rsp_rdata_o == '0)); // R3

    AST_IDENT_READ: assert property (@(posedge clk) disable iff (rst)
        (priv_ok && !req_we_i && req_idx_i == '0)
        |=> (rsp_rdata_o == {$past(cpu_num_i), $past(core_num_i)} && !rsp_fault_o)); // R4

    AST_IDENT_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (priv_ok && req_we_i && req_idx_i == '0) |=> !rsp_fault_o); // R5

    AST_FLAGS_RO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (priv_ok && !req_we_i && req_idx_i == IDX_W'(3))
        |=> (rsp_rdata_o[CR_W-1:4] == '0 && rsp_rdata_o[2:1] == 2'b00)); // R8

    AST_PTE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (priv_ok && req_we_i && req_idx_i == IDX_W'(3))
        |=> (pte_en_o == $past(req_wdata_i[0]))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!rsp_fault_o && rsp_rdata_o == '0)); // R10

endmodule

bind ctrl_reg_file cr_checker #(.IDX_W(IDX_W), .NUM_CR(NUM_CR)) u_cr_checker (
    .clk         (clk),
    .rst         (rst),
    .priv_i      (priv_i),
    .cpu_num_i   (cpu_num_i),
    .core_num_i  (core_num_i),
    .req_valid_i (req_valid_i),
    .req_idx_i   (req_idx_i),
    .req_we_i    (req_we_i),
    .req_wdata_i (req_wdata_i),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_fault_o (rsp_fault_o),
    .pte_en_o    (pte_en_o)
);

// File: tb/tb_ctrl_reg_file.sv
module tb_ctrl_reg_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        priv = 1'b0;
    logic [15:0] cpu_num = 16'h1234;
    logic [15:0] core_num = 16'hABCD;
    logic        valid = 1'b0;
    logic [2:0]  idx = 3'd0;
    logic        we = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        fault;
    logic        pte;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit model_live = 1'b0;

    // Behavioural reference state
    logic [31:0] m_evt, m_pgt, m_flg;
    logic [31:0] e_rdata;
    logic        e_fault;

    always #10 clk = ~clk;   // 50 MHz

    ctrl_reg_file dut (
        .clk         (clk),
        .rst         (rst),
        .priv_i      (priv),
        .cpu_num_i   (cpu_num),
        .core_num_i  (core_num),
        .req_valid_i (valid),
        .req_idx_i   (idx),
        .req_we_i    (we),
        .req_wdata_i (wdata),
        .rsp_rdata_o (rdata),
        .rsp_fault_o (fault),
        .pte_en_o    (pte)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_evt = 0; m_pgt = 0; m_flg = 0;
            e_rdata = 0; e_fault = 0;
            model_live = 1'b1;
        end else if (valid && (!priv || idx > 3)) begin
            e_fault = 1; e_rdata = 0;
        end else if (valid && we) begin
            e_fault = 0; e_rdata = 0;
            if (idx == 1) m_evt = wdata;
            else if (idx == 2) m_pgt = wdata;
            else if (idx == 3) m_flg = wdata & 32'h0000_0009;
        end else if (valid) begin
            e_fault = 0;
            case (idx)
                3'd0:    e_rdata = {cpu_num, core_num};
                3'd1:    e_rdata = m_evt;
                3'd2:    e_rdata = m_pgt;
                default: e_rdata = m_flg;
            endcase
        end else begin
            e_fault = 0; e_rdata = 0;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (model_live) begin
            check("rdata", rdata, e_rdata);
            check("fault", {31'b0, fault}, {31'b0, e_fault});
            check("pte_en", {31'b0, pte}, {31'b0, m_flg[0]});
        end
    end

    task automatic acc(input logic p, input logic w, input logic [2:0] i,
                       input logic [31:0] d, input string t);
        tag = t;
        priv = p; we = w; idx = i; wdata = d; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0; we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        check("reset rdata", rdata, 32'h0);
        check("reset fault", {31'b0, fault}, 32'h0);
        check("reset pte", {31'b0, pte}, 32'h0);
        rst = 1'b0;
        idle(1);
        acc(1, 0, 3'd1, 0, "R1");
        check("reset evt zero", rdata, 32'h0);
        acc(1, 0, 3'd3, 0, "R1");
        check("reset flags zero", rdata, 32'h0);

        // R6, R7: full-width, unaligned values
        acc(1, 1, 3'd1, 32'hDEAD_BEE3, "R6");
        acc(1, 0, 3'd1, 0, "R6");
        check("evt readback", rdata, 32'hDEAD_BEE3);
        acc(1, 1, 3'd2, 32'h0000_0001, "R7");
        acc(1, 0, 3'd2, 0, "R7");
        check("pgt readback", rdata, 32'h0000_0001);

        // R2: unprivileged accesses fault and change nothing
        acc(0, 1, 3'd1, 32'h1111_1111, "R2");
        check("unpriv write fault", {31'b0, fault}, 32'h1);
        acc(0, 0, 3'd2, 0, "R2");
        check("unpriv read data", rdata, 32'h0);
        acc(0, 1, 3'd3, 32'hF, "R2");
        check("unpriv pte held", {31'b0, pte}, 32'h0);
        acc(1, 0, 3'd1, 0, "R2");
        check("evt kept", rdata, 32'hDEAD_BEE3);

        // R3: indices above 3
        acc(1, 1, 3'd4, 32'hFFFF_FFFF, "R3");
        check("idx4 fault", {31'b0, fault}, 32'h1);
        acc(1, 0, 3'd7, 0, "R3");
        check("idx7 data", rdata, 32'h0);

        // R4, R5: identity word
        acc(1, 0, 3'd0, 0, "R4");
        check("ident", rdata, 32'h1234_ABCD);
        acc(1, 1, 3'd0, 32'h5555_5555, "R5");
        check("ident write no fault", {31'b0, fault}, 32'h0);
        cpu_num = 16'h0000; core_num = 16'h0007;
        acc(1, 0, 3'd0, 0, "R5");
        check("ident after write", rdata, 32'h0000_0007);

        // R8, R9: flag word masking and paging enable
        acc(1, 1, 3'd3, 32'hFFFF_FFFF, "R8");
        check("pte set", {31'b0, pte}, 32'h1);
        acc(1, 0, 3'd3, 0, "R8");
        check("flags masked", rdata, 32'h0000_0009);
        acc(1, 1, 3'd3, 32'h0000_0006, "R9");
        check("pte cleared", {31'b0, pte}, 32'h0);
        acc(1, 0, 3'd3, 0, "R8");
        check("ro bits zero", rdata, 32'h0);

        // R10: back-to-back requests and idle gaps
        acc(1, 1, 3'd2, 32'hCAFE_0000, "R10");
        acc(1, 0, 3'd2, 0, "R10");
        check("b2b read", rdata, 32'hCAFE_0000);
        acc(0, 0, 3'd2, 0, "R10");
        check("b2b fault", {31'b0, fault}, 32'h1);
        idle(1);
        check("idle quiet", {31'b0, fault}, 32'h0);

        // R1: reset in mid-run
        tag = "R1";
        acc(1, 1, 3'd3, 32'h1, "R1");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("mid reset pte", {31'b0, pte}, 32'h0);
        acc(1, 0, 3'd2, 0, "R1");
        check("mid reset pgt", rdata, 32'h0);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule